// File: doc/BRIEF.md
# Dual-Clock FIFO with Lookahead Mode

This block buffers words between a write clock domain and a read clock domain that may run at unrelated rates or share one clock. The pointers are kept in binary for addressing and cross between domains as gray code through two-flop synchronisers. Each side decides full or empty from its own pointer and a synchronised copy of the other side's pointer.

One of two operating modes is latched while reset is held. In standard mode every word, including the first, has to be requested with the read enable. Its two flags are an active-low full and an active-low empty. In lookahead mode the oldest word moves into the output register on its own and is announced on the read-side flag. The output register then counts as one extra storage slot, so the write side admits one more word. The same two flag pins carry both meanings, and their polarity changes with the mode. An output enable gates the data bus, and a separate drive-enable output marks when the bus would be driven.

Top module: `dcfifo_la`

## Requirements
- R1: The mode is taken from `mode_sel` while reset is high: 0 selects standard, 1 selects lookahead. Changes to `mode_sel` after reset has been released have no effect.
- R2: Right after reset, `wr_flag` = 1 and `rd_flag` = 0 in standard mode. In lookahead mode, `wr_flag` = 0 and `rd_flag` = 1.
- R3: In standard mode, with no reads since reset, `wr_flag` drops to 0 (full) right after the DEPTH-th accepted write. Writes requested while full are dropped and never reach the output.
- R4: In lookahead mode, with no reads since reset, `wr_flag` rises to 1 (no space) only after DEPTH+1 writes. Writes requested while it is 1 are dropped.
- R5: After a read frees space in a full FIFO, `wr_flag` leaves its full value in the second write-clock cycle after the read edge.
- R6: In standard mode, a write into an empty FIFO raises `rd_flag` (0 = empty, 1 = data) in the second read-clock cycle after the write edge.
- R7: In standard mode, a stored word reaches `rd_data` only at a read edge with `rd_en_n` = 0. While `rd_en_n` = 1, the output register keeps its value.
- R8: In lookahead mode, the first word written into an empty FIFO appears on `rd_data` at the third read-clock edge after the write, without any read request. `rd_flag` falls to 0 (data valid) at that same edge.
- R9: In lookahead mode, a read with `rd_en_n` = 0 that consumes the last word sets `rd_flag` to 1. The last word stays on `rd_data`.
- R10: A read requested while the FIFO is empty does not change the read pointer or the output register.
- R11: With `oe_n` = 1, `rd_data_en` = 0 and `rd_data` is all zeros. With `oe_n` = 0, `rd_data_en` = 1 and `rd_data` shows the output register. `oe_n` never alters the stored output word.
- R12: Words leave in the order they were accepted, across repeated wrap-around of the storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain; samples `mode_sel` |
| rd_clk | input | 1 | Read clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain; samples `mode_sel` |
| mode_sel | input | 1 | Mode selection, 0 standard, 1 lookahead, sampled during reset |
| wr_en_n | input | 1 | Active-low write request |
| wr_data | input | DW | Write data |
| wr_flag | output | 1 | Standard: 0 = full. Lookahead: 1 = no space |
| rd_en_n | input | 1 | Active-low read request |
| rd_flag | output | 1 | Standard: 0 = empty. Lookahead: 0 = output word valid |
| oe_n | input | 1 | Active-low output enable |
| rd_data | output | DW | Output register contents, zero while disabled |
| rd_data_en | output | 1 | High when the data bus would be driven |

## Verification
The bench goes after the flag edges one cycle at a time. A synchroniser chain that is one stage too short or too long moves the full release or the empty release by a cycle, and the bench sees that cycle. It fills the FIFO to DEPTH in standard mode and to DEPTH+1 in lookahead mode. A design that forgot the output register slot, or that let an overflow write through, would block one word early or return a word that should have been dropped. It reads an empty FIFO, drains the last word in lookahead mode, toggles the mode pin after reset and gates the output. Any of the following would change the output register or the flag where the model keeps them: a spurious pop, lost data after the final read, a mode that follows the pin live, or a gated bus that corrupts the stored word.

// File: rtl/dcfifo_la_pkg.sv
package dcfifo_la_pkg;
    typedef enum logic {
        MODE_STD = 1'b0,
        MODE_LA  = 1'b1
    } fifo_mode_e;
endpackage

// File: rtl/dcfifo_la_sync.sv
module dcfifo_la_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.stage1 = din;
        s_d.stage2 = s_q.stage1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign dout = s_q.stage2;
endmodule

// File: rtl/dcfifo_la_mem.sv
module dcfifo_la_mem #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store_q[waddr] <= wdata;
    end

    assign rdata = store_q[raddr];
endmodule

// File: rtl/dcfifo_la_wctl.sv
module dcfifo_la_wctl
    import dcfifo_la_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_sel,
    input  logic          wen_n,
    input  logic [PW-1:0] rptr_sync,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [PW-1:0] wptr_gray,
    output logic          mode_la,
    output logic          wr_flag
);
    localparam logic [PW-1:0] PTR_ONE = PW'(1);

    typedef struct packed {
        fifo_mode_e    mode;
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } wst_t;

    wst_t s_d, s_q;
    logic full;
    logic accept;

    always_comb begin
        s_d    = s_q;
        full   = (s_q.gray == {~rptr_sync[PW-1:PW-2], rptr_sync[PW-3:0]});
        accept = !wen_n && !full;
        if (accept) begin
            s_d.bin  = s_q.bin + PTR_ONE;
            s_d.gray = s_d.bin ^ (s_d.bin >> 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '{mode: fifo_mode_e'(mode_sel), bin: '0, gray: '0};
        else     s_q <= s_d;
    end

    assign mem_we    = accept;
    assign mem_waddr = s_q.bin[AW-1:0];
    assign wptr_gray = s_q.gray;
    assign mode_la   = (s_q.mode == MODE_LA);
    assign wr_flag   = mode_la ? full : !full;
endmodule

// File: rtl/dcfifo_la_rctl.sv
module dcfifo_la_rctl
    import dcfifo_la_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_sel,
    input  logic          ren_n,
    input  logic [PW-1:0] wptr_sync,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_raddr,
    output logic [PW-1:0] rptr_gray,
    output logic          empty,
    output logic [DW-1:0] dout,
    output logic          mode_la,
    output logic          rd_flag
);
    localparam logic [PW-1:0] PTR_ONE = PW'(1);

    typedef struct packed {
        fifo_mode_e    mode;
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic [DW-1:0] dout;
        logic          ovalid;
    } rst_t;

    rst_t s_d, s_q;
    logic pop;
    logic drop;

    always_comb begin
        s_d   = s_q;
        empty = (s_q.gray == wptr_sync);
        pop   = 1'b0;
        drop  = 1'b0;
        case (s_q.mode)
            MODE_LA: begin
                pop  = !empty && (!s_q.ovalid || !ren_n);
                drop = !pop && !ren_n && s_q.ovalid;
            end
            default: pop = !ren_n && !empty;
        endcase
        if (pop) begin
            s_d.bin    = s_q.bin + PTR_ONE;
            s_d.gray   = s_d.bin ^ (s_d.bin >> 1);
            s_d.dout   = mem_rdata;
            s_d.ovalid = 1'b1;
        end else if (drop) begin
            s_d.ovalid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '{mode: fifo_mode_e'(mode_sel), bin: '0, gray: '0,
                          dout: '0, ovalid: 1'b0};
        else     s_q <= s_d;
    end

    assign mem_raddr = s_q.bin[AW-1:0];
    assign rptr_gray = s_q.gray;
    assign dout      = s_q.dout;
    assign mode_la   = (s_q.mode == MODE_LA);
    assign rd_flag   = mode_la ? !s_q.ovalid : !empty;
endmodule

// File: rtl/dcfifo_la.sv
module dcfifo_la #(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic          wr_clk,
    input  logic          wr_rst,
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  logic          mode_sel,
    input  logic          wr_en_n,
    input  logic [DW-1:0] wr_data,
    output logic          wr_flag,
    input  logic          rd_en_n,
    output logic          rd_flag,
    input  logic          oe_n,
    output logic [DW-1:0] rd_data,
    output logic          rd_data_en
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [AW-1:0] mem_raddr;
    logic [DW-1:0] mem_rdata;
    logic [PW-1:0] wptr_gray;
    logic [PW-1:0] rptr_gray;
    logic [PW-1:0] wptr_in_rd;
    logic [PW-1:0] rptr_in_wr;
    logic          wr_la;
    logic          rd_la;
    logic          rd_empty;
    logic [DW-1:0] rd_dout;

    dcfifo_la_wctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wctl (
        .clk(wr_clk), .rst(wr_rst), .mode_sel(mode_sel), .wen_n(wr_en_n),
        .rptr_sync(rptr_in_wr), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .wptr_gray(wptr_gray), .mode_la(wr_la), .wr_flag(wr_flag)
    );

    dcfifo_la_rctl #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rctl (
        .clk(rd_clk), .rst(rd_rst), .mode_sel(mode_sel), .ren_n(rd_en_n),
        .wptr_sync(wptr_in_rd), .mem_rdata(mem_rdata), .mem_raddr(mem_raddr),
        .rptr_gray(rptr_gray), .empty(rd_empty), .dout(rd_dout),
        .mode_la(rd_la), .rd_flag(rd_flag)
    );

    dcfifo_la_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .din(wptr_gray), .dout(wptr_in_rd)
    );

    dcfifo_la_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .din(rptr_gray), .dout(rptr_in_wr)
    );

    dcfifo_la_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    assign rd_data    = oe_n ? '0 : rd_dout;
    assign rd_data_en = !oe_n;
endmodule

// File: rtl/dcfifo_la_chk.sv
module dcfifo_la_chk #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    parameter int PW    = $clog2(DEPTH) + 1
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          wr_en_n,
    input logic          wr_flag,
    input logic          rd_en_n,
    input logic          rd_flag,
    input logic [PW-1:0] wptr_g,
    input logic [PW-1:0] rptr_g,
    input logic          wr_la,
    input logic          rd_la,
    input logic          rd_empty,
    input logic [DW-1:0] rd_dout
);
    AST_STD_FULL_BLOCKS: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (!wr_la && !wr_flag && !wr_en_n) |=> $stable(wptr_g)); // R3

    AST_LA_FULL_BLOCKS: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_la && wr_flag && !wr_en_n) |=> $stable(wptr_g)); // R4

    AST_EMPTY_NO_POP: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_empty |=> $stable(rptr_g)); // R10

    AST_HOLD_NO_READ: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en_n && !(rd_la && rd_flag)) |=> $stable(rd_dout)); // R7

    AST_LA_LAST_READ: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_la && !rd_flag && !rd_en_n && rd_empty) |=> (rd_flag && $stable(rd_dout))); // R9
endmodule

bind dcfifo_la dcfifo_la_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .rd_clk(rd_clk), .rd_rst(rd_rst),
    .wr_en_n(wr_en_n), .wr_flag(wr_flag), .rd_en_n(rd_en_n), .rd_flag(rd_flag),
    .wptr_g(wptr_gray), .rptr_g(rptr_gray), .wr_la(wr_la), .rd_la(rd_la),
    .rd_empty(rd_empty), .rd_dout(rd_dout)
);

// File: tb/dcfifo_la_test.sv
module dcfifo_la_test;
    localparam int DW    = 8;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst, mode_sel, wen_n, ren_n, oe_n;
    logic [DW-1:0] wdata;
    logic          wr_flag, rd_flag, rd_data_en;
    logic [DW-1:0] rd_data;

    dcfifo_la #(.DW(DW), .DEPTH(DEPTH)) uut (
        .wr_clk(clk), .wr_rst(rst), .rd_clk(clk), .rd_rst(rst),
        .mode_sel(mode_sel), .wr_en_n(wen_n), .wr_data(wdata), .wr_flag(wr_flag),
        .rd_en_n(ren_n), .rd_flag(rd_flag), .oe_n(oe_n), .rd_data(rd_data),
        .rd_data_en(rd_data_en)
    );

    // behavioural reference: counts, delayed views and a word queue
    int            wtot, rtot, w_s1, w_s2, r_s1, r_s2;
    bit            m_la, m_ov;
    logic [DW-1:0] m_dout;
    logic [DW-1:0] m_q [$];
    int            n_cmp = 0, n_bad = 0;
    bit            done = 0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic mdl_step();
        bit full, empty, acc, pop, drop;
        full  = (wtot - r_s2) == DEPTH;
        empty = (w_s2 == rtot);
        acc   = !wen_n && !full;
        if (m_la) begin
            pop  = !empty && (!m_ov || !ren_n);
            drop = !pop && !ren_n && m_ov;
        end else begin
            pop  = !ren_n && !empty;
            drop = 1'b0;
        end
        r_s2 = r_s1; r_s1 = rtot;
        w_s2 = w_s1; w_s1 = wtot;
        if (pop) begin
            m_dout = m_q.pop_front();
            rtot++;
            m_ov = 1'b1;
        end
        if (drop) m_ov = 1'b0;
        if (acc) begin
            m_q.push_back(wdata);
            wtot++;
        end
    endtask

    task automatic compare(string dtag);
        bit full, empty;
        full  = (wtot - r_s2) == DEPTH;
        empty = (w_s2 == rtot);
        chk(m_la ? "R4" : "R5", "wr_flag", wr_flag, m_la ? full : !full);
        chk(m_la ? "R8" : "R6", "rd_flag", rd_flag, m_la ? !m_ov : !empty);
        chk(dtag, "rd_data", rd_data, oe_n ? '0 : m_dout);
        chk("R11", "rd_data_en", rd_data_en, !oe_n);
    endtask

    task automatic tick(string dtag = "R12");
        mdl_step();
        @(posedge clk);
        @(negedge clk);
        compare(dtag);
    endtask

    task automatic do_reset(bit la);
        rst = 1'b1; mode_sel = la; wen_n = 1'b1; ren_n = 1'b1; oe_n = 1'b0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        wtot = 0; rtot = 0; w_s1 = 0; w_s2 = 0; r_s1 = 0; r_s2 = 0;
        m_la = la; m_ov = 1'b0; m_dout = '0; m_q.delete();
        chk("R2", "wr_flag after reset", wr_flag, la ? 0 : 1);
        chk("R2", "rd_flag after reset", rd_flag, la ? 1 : 0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_bad++;
            $display("FAIL R12 watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // ---------------- standard mode ----------------
        do_reset(1'b0);
        mode_sel = 1'b1;
        ren_n = 1'b0; tick("R10"); tick("R10"); ren_n = 1'b1;
        chk("R10", "empty read leaves output", rd_data, 0);
        chk("R1", "standard kept after pin change", rd_flag, 0);

        wen_n = 1'b0; wdata = 8'hA1; tick(); wen_n = 1'b1;
        chk("R6", "flag at write edge", rd_flag, 0);
        tick(); chk("R6", "flag one edge later", rd_flag, 0);
        tick(); chk("R6", "flag two edges later", rd_flag, 1);
        tick("R7"); chk("R7", "no request no word", rd_data, 0);
        ren_n = 1'b0; tick("R7"); ren_n = 1'b1;
        chk("R7", "requested word", rd_data, 8'hA1);
        tick("R7"); chk("R7", "held without request", rd_data, 8'hA1);

        for (int i = 0; i < 9; i++) begin
            wen_n = 1'b0; wdata = 8'h10 + 8'(i); tick("R3");
            if (i == 6) chk("R3", "not full after D-1", wr_flag, 1);
            if (i == 7) chk("R3", "full after D", wr_flag, 0);
        end
        wen_n = 1'b1;
        tick(); tick();
        ren_n = 1'b0; tick("R7"); ren_n = 1'b1;
        chk("R5", "full at read edge", wr_flag, 0);
        chk("R7", "first stored word", rd_data, 8'h10);
        tick(); chk("R5", "full one edge later", wr_flag, 0);
        tick(); chk("R5", "released two edges later", wr_flag, 1);

        ren_n = 1'b0; repeat (7) tick("R3"); ren_n = 1'b1;
        chk("R3", "last kept word, overflow dropped", rd_data, 8'h17);
        chk("R3", "empty after drain", rd_flag, 0);
        ren_n = 1'b0; tick("R10"); ren_n = 1'b1;
        chk("R10", "read when empty ignored", rd_data, 8'h17);

        oe_n = 1'b1; tick("R11");
        chk("R11", "gated data", rd_data, 0);
        chk("R11", "enable low", rd_data_en, 0);
        oe_n = 1'b0; tick("R11");
        chk("R11", "word kept under gating", rd_data, 8'h17);

        for (int i = 0; i < 60; i++) begin
            wen_n = (i % 3 == 2); ren_n = (i % 5 == 1); wdata = 8'h40 + 8'(i);
            tick("R12");
        end
        wen_n = 1'b1; ren_n = 1'b0; repeat (12) tick("R12"); ren_n = 1'b1;

        // ---------------- lookahead mode ----------------
        do_reset(1'b1);
        mode_sel = 1'b0;
        wen_n = 1'b0; wdata = 8'hC3; tick(); wen_n = 1'b1;
        chk("R8", "not valid at write edge", rd_flag, 1);
        tick(); chk("R8", "not valid after one edge", rd_flag, 1);
        tick(); chk("R8", "not valid after two edges", rd_flag, 1);
        tick("R8");
        chk("R8", "valid at third edge", rd_flag, 0);
        chk("R8", "word fell through", rd_data, 8'hC3);
        chk("R1", "lookahead kept after pin change", rd_flag, 0);
        ren_n = 1'b0; tick("R9"); ren_n = 1'b1;
        chk("R9", "flag high after last read", rd_flag, 1);
        chk("R9", "last word kept", rd_data, 8'hC3);

        for (int i = 0; i < 10; i++) begin
            wen_n = 1'b0; wdata = 8'h20 + 8'(i); tick("R4");
            if (i == 7) chk("R4", "ready after D writes", wr_flag, 0);
            if (i == 8) chk("R4", "blocked after D+1 writes", wr_flag, 1);
        end
        wen_n = 1'b1;
        tick(); tick(); tick();
        ren_n = 1'b0; repeat (9) tick("R9"); ren_n = 1'b1;
        chk("R9", "drained flag", rd_flag, 1);
        chk("R4", "extra write dropped", rd_data, 8'h28);

        for (int i = 0; i < 70; i++) begin
            wen_n = (i % 4 == 3); ren_n = (i % 3 == 0); wdata = 8'h80 + 8'(i);
            tick("R12");
        end
        wen_n = 1'b1; ren_n = 1'b0; repeat (14) tick("R12"); ren_n = 1'b1;
        tick("R12");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule